// File: doc/BRIEF.md
# SPI Slave with Ready Handshake

This block is a serial peripheral slave that lives entirely in the system clock domain. The serial clock, chip select and data-in lines from the external master are oversampled through two-flop synchronizers. Edges of the serial clock are found by comparing successive synchronized samples. One word is shifted out and one word is shifted in per transfer, most significant bit first.

A polarity input chooses which physical serial clock edge launches output data and which edge samples input data. Software writes a transmit word with a one-cycle load strobe, which raises a pending flag. When chip select falls, the block drives an active-low ready line to the master, but only if such a fresh word is pending. The ready line is released a few system clocks after the final sampling edge of the word. At that same point the block hands the received word to the system side and clears the pending flag.

Top module: `spi_slave_hs`

## Requirements
- R1: After reset, `spi_ena_n` is 1, `spi_miso` is 0, `rx_done` is 0 and `tx_pending` is 0.
- R2: A cycle with `tx_load` high stores `tx_word` and sets `tx_pending` to 1 from the next cycle on. `tx_pending` returns to 0 when the final bit of a word is sampled, unless `tx_load` is high in that same cycle.
- R3: After `spi_cs_n` falls, `spi_ena_n` goes to 0 within 6 system clocks if `tx_pending` was 1. Otherwise it stays 1.
- R4: `spi_ena_n` stays low until the final sampling edge of the word and is 1 again no later than 4 system clocks after that edge reaches the pin.
- R5: While `spi_cs_n` is low and before the first serial clock edge, `spi_miso` carries bit WORD_W-1 of the word being sent. Later bits follow in descending order, one per launch edge.
- R6: With `cpol` = 0, data is launched on rising `spi_clk` edges and sampled on falling edges. With `cpol` = 1, data is launched on falling edges and sampled on rising edges. The first edge of a word never shifts the output.
- R7: When the final bit is sampled, `rx_word` takes the received word, with the first bit received in bit WORD_W-1, and `rx_done` is high for exactly one cycle.
- R8: If `spi_cs_n` rises before the final bit, the transfer is abandoned. `spi_ena_n` is 1, no `rx_done` pulse occurs, `tx_pending` keeps its value, and the next transfer starts again from the first bit.
- R9: A transfer that begins with no pending word sends the last stored word again, or all zeros if none was ever stored.
- R10: While the synchronized chip select is high, `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock polarity select |
| tx_load | input | 1 | One-cycle strobe that stores `tx_word` |
| tx_word | input | WORD_W | Word to transmit |
| rx_word | output | WORD_W | Last complete received word |
| rx_done | output | 1 | One-cycle pulse when a word is received |
| tx_pending | output | 1 | A fresh transmit word waits to be sent |
| spi_clk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_ena_n | output | 1 | Active-low ready line to the master |

## Verification
A bit counter that drifts by one shows up at once in two places. The master reads a rotated or doubled word on `spi_miso`, and `rx_done` comes one edge early or late, which moves the release of `spi_ena_n` out of its four-clock window. A stuck pending flag is exposed at the next chip-select fall: the ready line then goes low when no word was loaded, or stays high when one was. An abort that leaves stale state behind corrupts the word of the transfer that follows. The bench mixes random polarity, data and load decisions, and compares every bit, flag and release time against a model of the word buffer.

// File: rtl/spi_slave_hs.sv
module spi_slave_hs #(
  parameter int WORD_W = 16,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done,
  output logic              tx_pending,
  input  logic              spi_clk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_ena_n
);

  logic [1:0] cs_m, ck_m, di_m;
  logic       cs_d, ck_d;
  logic       cs_s, ck_s, di_s;
  logic       busy;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] tx_buf, tx_sh, rx_sh;

  assign cs_s = cs_m[1];
  assign ck_s = ck_m[1];
  assign di_s = di_m[1];

  logic ck_rise, ck_fall, lead, trail, cs_start, last;
  assign ck_rise  = ck_s & ~ck_d;
  assign ck_fall  = ~ck_s & ck_d;
  assign lead     = cpol ? ck_fall : ck_rise;
  assign trail    = cpol ? ck_rise : ck_fall;
  assign cs_start = cs_d & ~cs_s;
  assign last     = busy & ~cs_s & trail & (cnt == CW'(WORD_W-1));

  assign spi_miso = busy & tx_sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m <= 2'b11;
      ck_m <= 2'b00;
      di_m <= 2'b00;
      cs_d <= 1'b1;
      ck_d <= 1'b0;
    end else begin
      cs_m <= {cs_m[0], spi_cs_n};
      ck_m <= {ck_m[0], spi_clk};
      di_m <= {di_m[0], spi_mosi};
      cs_d <= cs_s;
      ck_d <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf     <= '0;
      tx_pending <= 1'b0;
    end else begin
      if (tx_load)
        tx_buf <= tx_word;
      if (tx_load)
        tx_pending <= 1'b1;
      else if (last)
        tx_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_word   <= '0;
      rx_done   <= 1'b0;
      spi_ena_n <= 1'b1;
    end else begin
      rx_done <= 1'b0;
      if (cs_s) begin
        busy      <= 1'b0;
        cnt       <= '0;
        spi_ena_n <= 1'b1;
      end else if (cs_start) begin
        busy      <= 1'b1;
        cnt       <= '0;
        tx_sh     <= tx_buf;
        spi_ena_n <= ~tx_pending;
      end else if (busy) begin
        if (lead && cnt != '0)
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        if (trail) begin
          rx_sh <= {rx_sh[WORD_W-2:0], di_s};
          if (last) begin
            rx_word   <= {rx_sh[WORD_W-2:0], di_s};
            rx_done   <= 1'b1;
            cnt       <= '0;
            tx_sh     <= tx_buf;
            spi_ena_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_slave_hs_chk.sv
module spi_slave_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic tx_load,
  input logic tx_pending,
  input logic rx_done,
  input logic spi_ena_n,
  input logic spi_miso
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> !rx_done); // R7
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rx_done && !$past(tx_load) |-> !tx_pending); // R2
  AST_ENA_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> spi_ena_n); // R4
  AST_ENA_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) $fell(spi_ena_n) |-> $past(tx_pending)); // R3
  AST_CS_HIGH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> spi_ena_n); // R8
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_s && $past(cs_s) |-> !spi_miso); // R10

endmodule

bind spi_slave_hs spi_slave_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .tx_load(tx_load),
  .tx_pending(tx_pending), .rx_done(rx_done), .spi_ena_n(spi_ena_n), .spi_miso(spi_miso)
);

// File: tb/spi_slave_hs_bench.sv
module spi_slave_hs_bench;
  localparam int W = 16;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, cpol = 1'b0, tx_load = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic [W-1:0] rx_word;
  logic rx_done, tx_pending, spi_miso, spi_ena_n;
  logic spi_clk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;

  int checks = 0, failures = 0, done_cnt = 0;
  logic [W-1:0] last_rx = '0;
  logic [W-1:0] exp_buf = '0;
  bit pend = 1'b0;

  always #4 clk = ~clk;

  spi_slave_hs #(.WORD_W(W)) u_spi_slave_hs (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .tx_load(tx_load), .tx_word(tx_word),
    .rx_word(rx_word), .rx_done(rx_done), .tx_pending(tx_pending),
    .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ena_n(spi_ena_n)
  );

  always @(negedge clk) if (rx_done) begin
    done_cnt++;
    last_rx = rx_word;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ena(input bit p);
    return ~p;
  endfunction

  task automatic xfer(input bit pol, input bit load, input logic [W-1:0] wr,
                      input logic [W-1:0] mw, input int nbits);
    logic [W-1:0] got = '0;
    int d0;
    if (load) begin
      tx_word = wr; tx_load = 1'b1; wclk(1); tx_load = 1'b0;
      exp_buf = wr; pend = 1'b1;
      chk(tx_pending == 1'b1, "R2 pending set", tx_pending, 1);
    end
    cpol = pol; spi_clk = pol; wclk(4);
    spi_cs_n = 1'b0; spi_mosi = mw[W-1]; wclk(HALF);
    chk(spi_ena_n == exp_ena(pend), pend ? "R3 ena low" : "R9 ena high", spi_ena_n, exp_ena(pend));
    chk(spi_miso == exp_buf[W-1], "R5 first bit", spi_miso, exp_buf[W-1]);
    d0 = done_cnt;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = mw[W-1-i];
      spi_clk = ~spi_clk; wclk(HALF);
      got[W-1-i] = spi_miso;
      spi_clk = ~spi_clk;
      if (i == W-1) begin
        wclk(1);
        chk(spi_ena_n == exp_ena(pend), "R4 ena held", spi_ena_n, exp_ena(pend));
        wclk(3);
        chk(spi_ena_n == 1'b1, "R4 ena release", spi_ena_n, 1);
        chk(done_cnt == d0 + 1, "R7 one done", done_cnt, d0 + 1);
        chk(last_rx == mw, "R7 rx word", last_rx, mw);
        chk(tx_pending == 1'b0, "R2 pending clear", tx_pending, 0);
        wclk(2);
      end else begin
        wclk(HALF);
      end
    end
    if (nbits == W) begin
      chk(got == exp_buf, pol ? "R6 cpol1 word" : "R6 cpol0 word", got, exp_buf);
      pend = 1'b0;
      spi_cs_n = 1'b1; wclk(4);
    end else begin
      spi_cs_n = 1'b1; wclk(4);
      chk(spi_ena_n == 1'b1, "R8 abort ena", spi_ena_n, 1);
      chk(done_cnt == d0, "R8 abort no done", done_cnt, d0);
      chk(tx_pending == pend, "R8 abort pending", tx_pending, pend);
    end
    chk(spi_miso == 1'b0, "R10 miso idle", spi_miso, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    wclk(3);
    chk(spi_ena_n == 1'b1 && spi_miso == 1'b0 && rx_done == 1'b0 && tx_pending == 1'b0,
        "R1 reset", {spi_ena_n, spi_miso, rx_done, tx_pending}, 4'b1000);
    rst_n = 1'b1; wclk(3);
    xfer(1'b0, 1'b0, '0, 16'hA5C3, W);
    xfer(1'b0, 1'b1, 16'h8001, 16'h3C5A, W);
    xfer(1'b1, 1'b1, 16'h7FFE, 16'hFFFF, W);
    xfer(1'b1, 1'b0, '0, 16'h0000, W);
    xfer(1'b0, 1'b1, 16'hBEEF, 16'h1234, 5);
    xfer(1'b1, 1'b0, '0, 16'h9ABC, W);
    for (int k = 0; k < 24; k++)
      xfer(1'($urandom % 2), ($urandom % 4) != 0, W'($urandom), W'($urandom), W);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule